// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block holds the status and control word of a floating-point unit and raises the unit's arithmetic exception. After each completed arithmetic operation the datapath hands in a five-bit report of the conditions it met. The block replaces its per-operation flag field with that report and folds the same bits into a cause field. The cause field keeps its bits until software rewrites the register. When any cause bit meets its enable bit, the block requests an exception with a fixed code.

Software loads the word through a write mask and can read it back at any time. From the stored word the block drives two controls into the datapath: a truncating rounding select and a flush-to-zero select. Ordered results of equal and greater-than compares set or clear a condition bit. An unordered compare result is handled like a completed operation, and its exception report is taken from the same five-bit input.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the register reads zero, `exc_req` is low, `rnd_trunc` is low and `flush_zero` is low.
- R2: On `op_done`, flag bits 6:2 are replaced by `op_exc`. The bit order is: bit 2 inexact (`op_exc[0]`), bit 3 underflow, bit 4 overflow, bit 5 divide-by-zero, bit 6 invalid (`op_exc[4]`). Flags not reported are cleared.
- R3: On the same event, cause bits 16:12 are ORed with `op_exc` in the same bit order. Cause bits that are already set stay set.
- R4: `exc_req` is high for exactly the cycle after an update event in which (new cause AND enable bits 11:7) is nonzero. `exc_code` always reads 0x120.
- R5: A software write stores `sw_wdata` AND 0x0007FFFF. Bits 31:19 always read zero.
- R6: `rnd_trunc` is high exactly when bits 1:0 hold 01. Any other value selects round-to-nearest-even.
- R7: `flush_zero` follows the denormal bit at bit 18.
- R8: An ordered compare (`cmp_valid` with `cmp_unordered` low) writes `cmp_true` into condition bit 17 and changes no other bit.
- R9: An unordered compare is an update event, exactly like `op_done`. It uses `op_exc` and leaves bit 17 unchanged.
- R10: A software write in a cycle with `op_done` or `cmp_valid` is discarded.
- R11: With no event and no write, the register holds its value and `exc_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | An arithmetic operation completed this cycle |
| op_exc | input | 5 | Exception report: invalid, div-zero, overflow, underflow, inexact (MSB to LSB) |
| cmp_valid | input | 1 | A compare result is present |
| cmp_unordered | input | 1 | The compare was unordered |
| cmp_true | input | 1 | The compare relation held |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| rnd_trunc | output | 1 | Rounding control: truncate when high |
| flush_zero | output | 1 | Flush-to-zero control |
| exc_req | output | 1 | Exception request pulse |
| exc_code | output | 12 | Exception code, fixed at 0x120 |

## Verification
A reference model in the bench follows the register on every clock through several phases:
- Directed reports with single bits, all five bits and no bits. These separate the replaced flag field from the sticky cause field.
- Enable patterns that do and do not overlap the accumulated cause. These show whether the request comes from the cause field or only from the current report.
- Writes that collide with operations and compares. These expose the priority order.
- A stretch of random traffic. This mixes all inputs, including compares that arrive together with operations.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    parameter int DATA_W    = 32;
    parameter int NEXC      = 5;
    parameter int RM_W      = 2;
    parameter int FLAG_LSB  = 2;
    parameter int EN_LSB    = 7;
    parameter int CAUSE_LSB = 12;
    parameter int COND_BIT  = 17;
    parameter int DNRM_BIT  = 18;
    parameter int CODE_W    = 12;
    parameter logic [RM_W-1:0]   RM_TRUNC = 2'b01;
    parameter logic [CODE_W-1:0] EXC_CODE = 12'h120;

    localparam int USED_W = DNRM_BIT + 1;
    localparam logic [DATA_W-1:0] WR_MASK =
        {{(DATA_W-USED_W){1'b0}}, {USED_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] csr;
        logic              req;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_exc_eval.sv
module fpsr_exc_eval #(
    parameter int NEXC = 5
) (
    input  logic [NEXC-1:0] exc_in,
    input  logic [NEXC-1:0] cause_q,
    input  logic [NEXC-1:0] en_q,
    output logic [NEXC-1:0] flags_nx,
    output logic [NEXC-1:0] cause_nx,
    output logic            raise
);
    logic [NEXC-1:0] hit;

    for (genvar i = 0; i < NEXC; i++) begin : g_cond
        assign flags_nx[i] = exc_in[i];
        assign cause_nx[i] = cause_q[i] | exc_in[i];
        assign hit[i]      = cause_nx[i] & en_q[i];
    end

    assign raise = |hit;
endmodule

// File: rtl/fpsr_rm_decode.sv
module fpsr_rm_decode #(
    parameter int              RM_W     = 2,
    parameter logic [RM_W-1:0] RM_TRUNC = 2'b01
) (
    input  logic [RM_W-1:0] rm,
    input  logic            dnrm,
    output logic            trunc,
    output logic            ftz
);
    assign trunc = (rm == RM_TRUNC);
    assign ftz   = dnrm;
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [NEXC-1:0]   op_exc,
    input  logic              cmp_valid,
    input  logic              cmp_unordered,
    input  logic              cmp_true,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rnd_trunc,
    output logic              flush_zero,
    output logic              exc_req,
    output logic [CODE_W-1:0] exc_code
);
    fpsr_state_t st_d, st_q;

    logic [NEXC-1:0] flags_nx, cause_nx;
    logic            raise;
    logic            upd_ev;

    assign upd_ev = op_done | (cmp_valid & cmp_unordered);

    fpsr_exc_eval #(.NEXC(NEXC)) u_eval (
        .exc_in   (op_exc),
        .cause_q  (st_q.csr[CAUSE_LSB +: NEXC]),
        .en_q     (st_q.csr[EN_LSB +: NEXC]),
        .flags_nx (flags_nx),
        .cause_nx (cause_nx),
        .raise    (raise)
    );

    fpsr_rm_decode #(.RM_W(RM_W), .RM_TRUNC(RM_TRUNC)) u_rm (
        .rm    (st_q.csr[RM_W-1:0]),
        .dnrm  (st_q.csr[DNRM_BIT]),
        .trunc (rnd_trunc),
        .ftz   (flush_zero)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (upd_ev) begin
            st_d.csr[FLAG_LSB +: NEXC]  = flags_nx;
            st_d.csr[CAUSE_LSB +: NEXC] = cause_nx;
            st_d.req                    = raise;
        end
        if (cmp_valid && !cmp_unordered) begin
            st_d.csr[COND_BIT] = cmp_true;
        end
        if (sw_we && !upd_ev && !cmp_valid) begin
            st_d.csr = sw_wdata & WR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.csr;
    assign exc_req  = st_q.req;
    assign exc_code = EXC_CODE;
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker
    import fpsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_done,
    input logic              cmp_valid,
    input logic              cmp_unordered,
    input logic              sw_we,
    input logic [DATA_W-1:0] rd_data,
    input logic              exc_req
);
    AST_REQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(op_done || (cmp_valid && cmp_unordered))); // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:USED_W] == '0); // R5

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || (cmp_valid && cmp_unordered)) |=>
        ((rd_data[CAUSE_LSB +: NEXC] & $past(rd_data[CAUSE_LSB +: NEXC]))
            == $past(rd_data[CAUSE_LSB +: NEXC]))); // R3

    AST_ORDERED_CMP_COND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_unordered && !op_done) |=>
        (rd_data[COND_BIT-1:0] == $past(rd_data[COND_BIT-1:0]))); // R8

    AST_WRITE_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && (op_done || cmp_valid)) |=>
        (rd_data[RM_W-1:0] == $past(rd_data[RM_W-1:0]))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && !cmp_valid && !sw_we) |=> ($stable(rd_data) && !exc_req)); // R11
endmodule

bind fp_status_unit fpsr_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_done       (op_done),
    .cmp_valid     (cmp_valid),
    .cmp_unordered (cmp_unordered),
    .sw_we         (sw_we),
    .rd_data       (rd_data),
    .exc_req       (exc_req)
);

// File: tb/sim_fp_status_unit.sv
module sim_fp_status_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_done, cmp_valid, cmp_unordered, cmp_true, sw_we;
    logic [4:0]  op_exc;
    logic [31:0] sw_wdata;
    logic [31:0] rd_data;
    logic        rnd_trunc, flush_zero, exc_req;
    logic [11:0] exc_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_csr;
    logic        m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
        .cmp_valid(cmp_valid), .cmp_unordered(cmp_unordered), .cmp_true(cmp_true),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .rd_data(rd_data),
        .rnd_trunc(rnd_trunc), .flush_zero(flush_zero),
        .exc_req(exc_req), .exc_code(exc_code)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "rd_data", rd_data, m_csr);
        chk(tag, "exc_req", {31'b0, exc_req}, {31'b0, m_req});
        chk("R6", "rnd_trunc", {31'b0, rnd_trunc}, {31'b0, m_csr[1:0] == 2'b01});
        chk("R7", "flush_zero", {31'b0, flush_zero}, {31'b0, m_csr[18]});
        chk("R4", "exc_code", {20'b0, exc_code}, 32'h120);
    endtask

    task automatic idle_inputs();
        op_done = 0; op_exc = 0; cmp_valid = 0; cmp_unordered = 0;
        cmp_true = 0; sw_we = 0; sw_wdata = 0;
    endtask

    task automatic step(input string tag);
        logic       upd;
        logic [4:0] cz;
        @(posedge clk);
        upd   = op_done || (cmp_valid && cmp_unordered);
        m_req = 1'b0;
        if (!rst_n) begin
            m_csr = '0;
        end else begin
            if (upd) begin
                cz = m_csr[16:12] | op_exc;
                m_csr[6:2]   = op_exc;
                m_csr[16:12] = cz;
                m_req = |(cz & m_csr[11:7]);
            end
            if (cmp_valid && !cmp_unordered) m_csr[17] = cmp_true;
            if (sw_we && !upd && !cmp_valid) m_csr = sw_wdata & 32'h0007FFFF;
        end
        @(negedge clk);
        compare_all(tag);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_csr = '0; m_req = 0;
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");

        // R5 masked write, R6 rm=11, R7 denormal set
        sw_we = 1; sw_wdata = 32'hFFFF_FFFF; step("R5");
        // clear, then rm=01 and enable invalid only
        sw_we = 1; sw_wdata = 32'h0000_0801; step("R6");
        // R2: inexact only, not enabled -> no request
        op_done = 1; op_exc = 5'b00001; step("R2");
        // R2/R4: invalid reported and enabled -> request
        op_done = 1; op_exc = 5'b10000; step("R4");
        step("R11");
        // R3: clean op, flags clear, cause keeps invalid -> request again
        op_done = 1; op_exc = 5'b00000; step("R3");
        // all five conditions
        op_done = 1; op_exc = 5'b11111; step("R2");
        // R5 rewrite clears cause, enable overflow, rm=10
        sw_we = 1; sw_wdata = 32'h0004_0202; step("R5");
        op_done = 1; op_exc = 5'b01010; step("R3");
        op_done = 1; op_exc = 5'b00100; step("R4");
        // R8 ordered compares
        cmp_valid = 1; cmp_true = 1; step("R8");
        cmp_valid = 1; cmp_true = 0; step("R8");
        cmp_valid = 1; cmp_true = 1; step("R8");
        // R9 unordered compare reports invalid; bit 17 unchanged
        cmp_valid = 1; cmp_unordered = 1; cmp_true = 0; op_exc = 5'b10000; step("R9");
        // R10 write collides with op and with compare
        sw_we = 1; sw_wdata = 32'h0000_0003; op_done = 1; op_exc = 5'b00001; step("R10");
        sw_we = 1; sw_wdata = 32'h0000_0003; cmp_valid = 1; cmp_true = 0; step("R10");
        step("R11"); step("R11");

        for (int i = 0; i < 400; i++) begin
            op_done       = ($urandom % 3) == 0;
            op_exc        = 5'($urandom);
            cmp_valid     = ($urandom % 4) == 0;
            cmp_unordered = ($urandom % 3) == 0;
            cmp_true      = 1'($urandom);
            sw_we         = ($urandom % 5) == 0;
            sw_wdata      = $urandom;
            step("R2");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule